// File: doc/BRIEF.md
# BCD Calendar Timebase

This block keeps the time of day and the calendar date as packed BCD words and advances them by one second on every tick of an internal one-second strobe. The strobe comes from a two-stage divider running on the real-time kernel clock. A short first stage, up to 7 bits wide, feeds a longer second stage, up to 15 bits wide. The tick period in kernel clocks is the product of the two programmed terminal counts, each plus one.

Software, or a controlling state machine, raises the initialization-mode input to stop the divider and the calendar. While that input is high it may load a new prescaler pair, a new time word and a new date word. When the input drops, counting starts again from a fresh divider phase. The calendar always runs in 24-hour format. Month lengths and February in leap years are handled, and the weekday uses a Monday-first code. The year is a two-digit BCD value that wraps from 99 to 00.

Top module: `bcd_calendar_timebase`

## Requirements
- R1: After reset the time word reads 0x000000 (00:00:00), the date word reads 0x00C101 (day 01, month 01, weekday 6, year 00), tick_1hz is low, and the prescaler pair is 127/255.
- R2: With first-stage count A and second-stage count S, tick_1hz is a one-cycle pulse. It rises for the first time (A+1)*(S+1) clocks after initialization mode is released, and then every (A+1)*(S+1) clocks.
- R3: While init_mode is high the divider is cleared, tick_1hz stays low, and the time and date words keep their values except where a load overwrites them.
- R4: The prescaler, time and date loads take effect on the next clock edge only while init_mode is high. Loads presented while init_mode is low change nothing. Reserved load bits (time bits 7 and 15, date bits 7:6) must be zero.
- R5: The time word packs seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, all BCD. The calendar advances on the clock edge that ends a cycle in which tick_1hz is high. Seconds wrap 59 to 00 and carry into minutes, and minutes wrap 59 to 00 and carry into hours.
- R6: Hours count 00 to 23. A wrap from 23 to 00 advances the day of month and the weekday on the same edge.
- R7: The day of month wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The month field advances in BCD, so 09 is followed by 10.
- R8: February ends after day 29 when the BCD year is a multiple of four, and after day 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R10: The date word packs the day of month in bits 5:0, the month in bits 12:8 (units in 11:8, tens in bit 12), the weekday in bits 15:13 and the year in bits 23:16. The weekday code is 1 for Monday through 7 for Sunday, and it advances from 7 to 1 on each day rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rtc | input | 1 | Real-time kernel clock |
| rst_rtc_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_mode | input | 1 | Initialization mode: holds the counters and enables loads |
| presc_load | input | 1 | Load strobe for the prescaler pair |
| presc_async_in | input | 7 | First-stage terminal count A |
| presc_sync_in | input | 15 | Second-stage terminal count S |
| time_load | input | 1 | Load strobe for the time word |
| time_in | input | 22 | Time word to load, BCD |
| date_load | input | 1 | Load strobe for the date word |
| date_in | input | 24 | Date word to load, BCD |
| time_out | output | 22 | Current time word |
| date_out | output | 24 | Current date word |
| tick_1hz | output | 1 | One-cycle strobe per divided period |

## Verification
A load made in initialization mode is visible on the outputs one edge after the strobe. The bench samples on the falling edge that follows that edge. The first tick is due N = (A+1)*(S+1) edges after the edge that first sees init_mode low. The bench counts falling edges from the release and expects the tick on count N, and again N counts later. The calendar moves one edge after the cycle in which the tick is high, so after each tick the bench waits one more falling edge before it compares the words against a bench model of one-second advance.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int TIME_W = 22;
  localparam int DATE_W = 24;

  typedef logic [7:0] bcd8_t;

  // two-digit BCD increment, no wrap handling
  function automatic bcd8_t bcd_inc8(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*T + O is a multiple of 4 exactly when 2*T + O is
  function automatic logic year_is_leap(bcd8_t yr);
    logic [1:0] sum;
    sum = {yr[4], 1'b0} + yr[1:0];
    return (sum == 2'b00);
  endfunction

  function automatic bcd8_t month_length(bcd8_t mon, bcd8_t yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_presc_div.sv
module rtc_presc_div #(
  parameter int              A_W   = 7,
  parameter int              S_W   = 15,
  parameter logic [A_W-1:0]  A_RST = 7'd127,
  parameter logic [S_W-1:0]  S_RST = 15'd255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_mode,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [S_W-1:0] s_in,
  output logic           tick
);

  logic [A_W-1:0] a_q, a_d, acnt_q, acnt_d;
  logic [S_W-1:0] s_q, s_d, scnt_q, scnt_d;
  logic           tick_q, tick_d;
  logic           a_end, s_end;

  assign a_end = (acnt_q == a_q);
  assign s_end = (scnt_q == s_q);

  always_comb begin
    a_d    = a_q;
    s_d    = s_q;
    acnt_d = acnt_q;
    scnt_d = scnt_q;
    tick_d = 1'b0;
    if (init_mode) begin
      acnt_d = '0;
      scnt_d = '0;
      if (load) begin
        a_d = a_in;
        s_d = s_in;
      end
    end else begin
      tick_d = a_end && s_end;
      if (a_end) begin
        acnt_d = '0;
        scnt_d = s_end ? '0 : scnt_q + 1'b1;
      end else begin
        acnt_d = acnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= A_RST;
      s_q    <= S_RST;
      acnt_q <= '0;
      scnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      s_q    <= s_d;
      acnt_q <= acnt_d;
      scnt_q <= scnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R2: a strobe coincides with a fresh divider phase
  p_tick_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (acnt_q == '0) && (scnt_q == '0));

  // R4: prescaler pair frozen outside initialization mode
  p_presc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_mode) |-> $stable(a_q) && $stable(s_q));

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int         W         = 7,
  parameter logic [7:0] LIMIT     = 8'h59,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         wrap
);

  logic [W-1:0] val_q, val_d, inc;

  always_comb begin
    if (val_q[3:0] == 4'd9) inc = {val_q[W-1:4] + 1'b1, 4'd0};
    else                    inc = {val_q[W-1:4], val_q[3:0] + 4'd1};
  end

  assign wrap = step && (val_q >= LIMIT[W-1:0]);

  always_comb begin
    val_d = val_q;
    if (load)      val_d = load_val;
    else if (step) val_d = wrap ? '0 : inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RESET_VAL[W-1:0];
    else        val_q <= val_d;
  end

  assign value = val_q;

  // R5 (also R6 for the hour instance): a step at the limit returns to zero
  p_field_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && (val_q == LIMIT[W-1:0]) |=> (val_q == '0));

endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [5:0]  ld_day,
  input  logic [4:0]  ld_mon,
  input  logic [2:0]  ld_wday,
  input  logic [7:0]  ld_year,
  input  logic        day_roll,
  output logic [23:0] date_word
);

  logic [5:0] day_q, day_d, day_inc;
  logic [4:0] mon_q, mon_d, mon_inc;
  logic [2:0] wd_q, wd_d;
  logic [7:0] yr_q, yr_d;
  bcd8_t      dim;
  logic       month_end, year_end;

  assign dim       = month_length({3'b000, mon_q}, yr_q);
  assign month_end = ({2'b00, day_q} >= dim);
  assign year_end  = (mon_q >= 5'h12);

  always_comb begin
    if (day_q[3:0] == 4'd9) day_inc = {day_q[5:4] + 2'd1, 4'd0};
    else                    day_inc = {day_q[5:4], day_q[3:0] + 4'd1};
    if (mon_q[3:0] == 4'd9) mon_inc = 5'h10;
    else                    mon_inc = {mon_q[4], mon_q[3:0] + 4'd1};
  end

  always_comb begin
    day_d = day_q;
    mon_d = mon_q;
    wd_d  = wd_q;
    yr_d  = yr_q;
    if (load) begin
      day_d = ld_day;
      mon_d = ld_mon;
      wd_d  = ld_wday;
      yr_d  = ld_year;
    end else if (day_roll) begin
      wd_d = (wd_q >= 3'd7) ? 3'd1 : wd_q + 3'd1;
      if (month_end) begin
        day_d = 6'h01;
        if (year_end) begin
          mon_d = 5'h01;
          yr_d  = (yr_q == 8'h99) ? 8'h00 : bcd_inc8(yr_q);
        end else begin
          mon_d = mon_inc;
        end
      end else begin
        day_d = day_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q <= 6'h01;
      mon_q <= 5'h01;
      wd_q  <= 3'd6;
      yr_q  <= 8'h00;
    end else begin
      day_q <= day_d;
      mon_q <= mon_d;
      wd_q  <= wd_d;
      yr_q  <= yr_d;
    end
  end

  assign date_word = {yr_q, wd_q, mon_q, 2'b00, day_q};

  // R10: Sunday is followed by Monday
  p_wday_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && !load && (wd_q == 3'd7) |=> (wd_q == 3'd1));

  // R9: December end goes to January
  p_month_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && !load && (mon_q == 5'h12) && month_end |=> (mon_q == 5'h01) && (day_q == 6'h01));

  // R7: the day never passes the month length on a rollover step
  p_day_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && !load && !month_end |=> (day_q != 6'h01));

endmodule

// File: rtl/bcd_calendar_timebase.sv
module bcd_calendar_timebase
  import rtc_cal_pkg::*;
#(
  parameter int                 ASYNC_W   = 7,
  parameter int                 SYNC_W    = 15,
  parameter logic [ASYNC_W-1:0] ASYNC_RST = 7'd127,
  parameter logic [SYNC_W-1:0]  SYNC_RST  = 15'd255
) (
  input  logic               clk_rtc,
  input  logic               rst_rtc_n,
  input  logic               init_mode,
  input  logic               presc_load,
  input  logic [ASYNC_W-1:0] presc_async_in,
  input  logic [SYNC_W-1:0]  presc_sync_in,
  input  logic               time_load,
  input  logic [TIME_W-1:0]  time_in,
  input  logic               date_load,
  input  logic [DATE_W-1:0]  date_in,
  output logic [TIME_W-1:0]  time_out,
  output logic [DATE_W-1:0]  date_out,
  output logic               tick_1hz
);

  localparam int NFIELD = 3;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_rtc or negedge rst_rtc_n) begin
    if (!rst_rtc_n) rst_sync_q <= 2'b00;
    else            rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic tick;
  logic advance;
  logic tload, dload;

  rtc_presc_div #(
    .A_W   (ASYNC_W),
    .S_W   (SYNC_W),
    .A_RST (ASYNC_RST),
    .S_RST (SYNC_RST)
  ) u_div (
    .clk       (clk_rtc),
    .rst_n     (rst_n_int),
    .init_mode (init_mode),
    .load      (presc_load),
    .a_in      (presc_async_in),
    .s_in      (presc_sync_in),
    .tick      (tick)
  );

  assign advance = tick && !init_mode;
  assign tload   = init_mode && time_load;
  assign dload   = init_mode && date_load;

  // seconds, minutes, hours as a carry chain of BCD fields
  logic [NFIELD-1:0] fstep, fwrap;
  logic [6:0]        sec_v, min_v;
  logic [5:0]        hour_v;

  for (genvar g = 0; g < NFIELD; g++) begin : g_time
    if (g == 0) begin : g_first
      assign fstep[g] = advance;
    end else begin : g_next
      assign fstep[g] = fwrap[g-1];
    end
    if (g == NFIELD - 1) begin : g_hour
      rtc_bcd_field #(.W(6), .LIMIT(8'h23)) u_field (
        .clk      (clk_rtc),
        .rst_n    (rst_n_int),
        .load     (tload),
        .load_val (time_in[21:16]),
        .step     (fstep[g]),
        .value    (hour_v),
        .wrap     (fwrap[g])
      );
    end else begin : g_ms
      logic [6:0] fval;
      rtc_bcd_field #(.W(7), .LIMIT(8'h59)) u_field (
        .clk      (clk_rtc),
        .rst_n    (rst_n_int),
        .load     (tload),
        .load_val (time_in[8*g +: 7]),
        .step     (fstep[g]),
        .value    (fval),
        .wrap     (fwrap[g])
      );
      if (g == 0) begin : g_sec
        assign sec_v = fval;
      end else begin : g_min
        assign min_v = fval;
      end
    end
  end

  rtc_date_unit u_date (
    .clk       (clk_rtc),
    .rst_n     (rst_n_int),
    .load      (dload),
    .ld_day    (date_in[5:0]),
    .ld_mon    (date_in[12:8]),
    .ld_wday   (date_in[15:13]),
    .ld_year   (date_in[23:16]),
    .day_roll  (fwrap[NFIELD-1]),
    .date_word (date_out)
  );

  assign time_out = {hour_v, 1'b0, min_v, 1'b0, sec_v};
  assign tick_1hz = tick;

  // R3: calendar holds in initialization mode unless overwritten
  p_hold_in_init_r3: assert property (@(posedge clk_rtc) disable iff (!rst_n_int)
    $past(init_mode) && !$past(time_load) |-> (time_out == $past(time_out)));

  // R5: outside initialization mode the time only moves after a tick
  p_update_on_tick_r5: assert property (@(posedge clk_rtc) disable iff (!rst_n_int)
    (time_out != $past(time_out)) && !$past(init_mode) |-> $past(tick));

  // R4: reserved load bits are zero
  p_load_rsvd_r4: assert property (@(posedge clk_rtc) disable iff (!rst_n_int)
    (time_load || date_load) |-> (time_in[7] == 1'b0) && (time_in[15] == 1'b0) && (date_in[7:6] == 2'b00));

endmodule

// File: tb/test_bcd_calendar_timebase.sv
`timescale 1ns/1ps
module test_bcd_calendar_timebase;

  logic        clk_rtc = 1'b0;
  logic        rst_rtc_n;
  logic        init_mode;
  logic        presc_load;
  logic [6:0]  presc_async_in;
  logic [14:0] presc_sync_in;
  logic        time_load;
  logic [21:0] time_in;
  logic        date_load;
  logic [23:0] date_in;
  logic [21:0] time_out;
  logic [23:0] date_out;
  logic        tick_1hz;

  always #2.5 clk_rtc = ~clk_rtc;

  bcd_calendar_timebase i_bcd_calendar_timebase (
    .clk_rtc        (clk_rtc),
    .rst_rtc_n      (rst_rtc_n),
    .init_mode      (init_mode),
    .presc_load     (presc_load),
    .presc_async_in (presc_async_in),
    .presc_sync_in  (presc_sync_in),
    .time_load      (time_load),
    .time_in        (time_in),
    .date_load      (date_load),
    .date_in        (date_in),
    .time_out       (time_out),
    .date_out       (date_out),
    .tick_1hz       (tick_1hz)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [21:0] mt;
  logic [23:0] md;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int b2i(logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int days_in(int mo, int yr);
    case (mo)
      2:           return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default:     return 31;
    endcase
  endfunction

  function automatic logic [21:0] pack_time(int h, int m, int s);
    logic [7:0] bh, bm, bs;
    bh = i2b(h); bm = i2b(m); bs = i2b(s);
    return {bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0]};
  endfunction

  function automatic logic [23:0] pack_date(int dy, int mo, int wd, int yr);
    logic [7:0] bd, bmo, by;
    bd = i2b(dy); bmo = i2b(mo); by = i2b(yr);
    return {by, 3'(wd), bmo[4:0], 2'b00, bd[5:0]};
  endfunction

  // one second of calendar advance, computed in binary
  function automatic logic [45:0] step_model(logic [21:0] t, logic [23:0] d);
    int s, m, h, dy, mo, yr, wd;
    s  = b2i({1'b0, t[6:0]});
    m  = b2i({1'b0, t[14:8]});
    h  = b2i({2'b0, t[21:16]});
    dy = b2i({2'b0, d[5:0]});
    mo = b2i({3'b0, d[12:8]});
    yr = b2i(d[23:16]);
    wd = int'(d[15:13]);
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0;
          wd = (wd == 7) ? 1 : wd + 1;
          dy++;
          if (dy > days_in(mo, yr)) begin
            dy = 1; mo++;
            if (mo == 13) begin
              mo = 1;
              yr = (yr + 1) % 100;
            end
          end
        end
      end
    end
    return {pack_date(dy, mo, wd, yr), pack_time(h, m, s)};
  endfunction

  task automatic program_cal(logic [6:0] a, logic [14:0] s, logic [21:0] t, logic [23:0] d);
    @(negedge clk_rtc);
    init_mode = 1'b1;
    presc_load = 1'b1; presc_async_in = a; presc_sync_in = s;
    time_load = 1'b1; time_in = t;
    date_load = 1'b1; date_in = d;
    @(negedge clk_rtc);
    presc_load = 1'b0; time_load = 1'b0; date_load = 1'b0;
    @(negedge clk_rtc);
    init_mode = 1'b0;
    mt = t; md = d;
  endtask

  // wait for a strobe, then one more edge for the calendar update
  task automatic next_second(string tag_t, string tag_d);
    {md, mt} = step_model(mt, md);
    @(negedge clk_rtc);
    while (!tick_1hz) @(negedge clk_rtc);
    @(negedge clk_rtc);
    check(tag_t, 32'(time_out), 32'(mt));
    check(tag_d, 32'(date_out), 32'(md));
  endtask

  task automatic measure_period(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk_rtc);
      cnt++;
    end while (!tick_1hz && cnt < 5000);
  endtask

  task automatic directed(logic [21:0] t, logic [23:0] d, logic [21:0] et, logic [23:0] ed, string tag);
    program_cal(7'd0, 15'd1, t, d);
    next_second(tag, tag);
    check(tag, 32'(time_out), 32'(et));
    check(tag, 32'(date_out), 32'(ed));
  endtask

  task automatic rand_state(output logic [21:0] t, output logic [23:0] d);
    int h, m, s, yr, mo, dy, wd, dim;
    yr  = int'($urandom % 100);
    mo  = 1 + int'($urandom % 12);
    dim = days_in(mo, yr);
    dy  = ($urandom % 3 == 0) ? dim : 1 + int'($urandom % dim);
    h   = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
    m   = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
    s   = ($urandom % 2 == 0) ? 59 - int'($urandom % 3) : int'($urandom % 60);
    wd  = 1 + int'($urandom % 7);
    t = pack_time(h, m, s);
    d = pack_date(dy, mo, wd, yr);
  endtask

  initial begin
    repeat (150000) @(posedge clk_rtc);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cnt;
    int ticks;
    logic [21:0] rt, held_t;
    logic [23:0] rd, held_d;
    void'($urandom(32'd4242));
    rst_rtc_n = 1'b0; init_mode = 1'b0;
    presc_load = 1'b0; presc_async_in = '0; presc_sync_in = '0;
    time_load = 1'b0; time_in = '0; date_load = 1'b0; date_in = '0;
    repeat (4) @(negedge clk_rtc);
    rst_rtc_n = 1'b1;
    repeat (4) @(negedge clk_rtc);

    // R1 reset state
    check("R1 time reset", 32'(time_out), 32'h0);
    check("R1 date reset", 32'(date_out), 32'h00C101);
    check("R1 tick reset", 32'(tick_1hz), 32'h0);
    // R1 default prescaler 127/255: no tick within a short window
    ticks = 0;
    repeat (200) begin
      @(negedge clk_rtc);
      if (tick_1hz) ticks++;
    end
    check("R1 default prescaler no early tick", 32'(ticks), 32'h0);

    // R2 period (A+1)*(S+1) = 3*5 = 15
    program_cal(7'd2, 15'd4, 22'h000000, 24'h00C101);
    check("R4 time load in init", 32'(time_out), 32'h0);
    measure_period(cnt);
    check("R2 first tick delay", 32'(cnt), 32'd15);
    @(negedge clk_rtc);
    check("R2 tick one cycle", 32'(tick_1hz), 32'h0);
    measure_period(cnt);
    check("R2 tick period", 32'(cnt + 1), 32'd15);

    // R4 prescaler load outside init ignored
    presc_load = 1'b1; presc_async_in = 7'd0; presc_sync_in = 15'd0;
    @(negedge clk_rtc);
    presc_load = 1'b0;
    measure_period(cnt);
    measure_period(cnt);
    check("R4 prescaler load ignored", 32'(cnt), 32'd15);

    // R4 time/date load outside init ignored
    program_cal(7'd127, 15'd255, 22'h101010, 24'h153215);
    repeat (2) @(negedge clk_rtc);
    time_load = 1'b1; time_in = 22'h225544;
    date_load = 1'b1; date_in = 24'h884128;
    @(negedge clk_rtc);
    time_load = 1'b0; date_load = 1'b0;
    repeat (2) @(negedge clk_rtc);
    check("R4 time load ignored", 32'(time_out), 32'h101010);
    check("R4 date load ignored", 32'(date_out), 32'h153215);

    // R3 hold in init mode
    program_cal(7'd0, 15'd1, 22'h000010, 24'h153215);
    repeat (5) @(negedge clk_rtc);
    init_mode = 1'b1;
    held_t = time_out; held_d = date_out;
    @(negedge clk_rtc);
    ticks = 0;
    repeat (30) begin
      @(negedge clk_rtc);
      if (tick_1hz) ticks++;
    end
    check("R3 no tick in init", 32'(ticks), 32'h0);
    check("R3 time held", 32'(time_out), 32'(held_t));
    check("R3 date held", 32'(date_out), 32'(held_d));
    init_mode = 1'b0;
    mt = held_t; md = held_d;
    next_second("R3 resume time", "R3 resume date");

    // directed corners
    directed(22'h123459, 24'h153215, 22'h123500, 24'h153215, "R5 seconds carry");
    directed(22'h125959, 24'h153215, 22'h130000, 24'h153215, "R5 minutes carry");
    directed(22'h235959, 24'h15E131, 22'h000000, 24'h152201, "R6 hour wrap to next day");
    directed(22'h235959, 24'h158430, 22'h000000, 24'h15A501, "R7 April 30 days");
    directed(22'h235959, 24'h15C131, 22'h000000, 24'h15E201, "R7 January 31 days");
    directed(22'h235959, 24'h152930, 22'h000000, 24'h155001, "R7 September to October");
    directed(22'h235959, 24'h246228, 22'h000000, 24'h248229, "R8 leap February 29");
    directed(22'h235959, 24'h234228, 22'h000000, 24'h236301, "R8 common February");
    directed(22'h235959, 24'h004229, 22'h000000, 24'h006301, "R8 leap year 00");
    directed(22'h235959, 24'h99F231, 22'h000000, 24'h002101, "R9 R10 year and weekday wrap");

    // constrained random scenarios
    for (int k = 0; k < 30; k++) begin
      rand_state(rt, rd);
      program_cal(7'd0, 15'd1, rt, rd);
      for (int j = 0; j < 4; j++) begin
        next_second("R5 R6 random time", "R7 R8 R9 R10 random date");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule